// File: doc/BRIEF.md
# Link Event Recorder with Trigger Freeze

This block is a black-box recorder for a communication link. Each link-up or link-down strobe is written into a small circular store as one entry carrying the cycle's timestamp, the direction of the transition and a two-bit cause code. The store keeps rolling, so the newest entries overwrite the oldest. Beside the store, four saturating counters tally link-up strobes, link-down strobes, retrains and reconnects.

A trigger input captures a window around a fault. The entries already held form the history before the fault. The entries from the trigger cycle and a programmable number of later entries are added after it. After that, the store stops taking writes until it is re-armed. The frozen window is read by index, oldest entry first, with one cycle of read latency. Both transitions can arrive in the same cycle, and neither is dropped.

Top module: `link_evt_logger`

## Requirements
- R1: `ts_o` is 0 after reset and increases by exactly 1 on every clock edge while out of reset.
- R2: Each accepted link-up or link-down strobe writes one entry, laid out as `{ts[TS_W-1:0], kind, cause[1:0]}`. `kind` is 1 for up and 0 for down. `cause` is 0 for reset, 1 for retrain, 2 for policy reject and 3 for physical drop. `ts` is the `ts_o` value of the cycle in which the strobe is asserted.
- R3: When up and down strobes arrive in the same cycle, both entries are written with the same timestamp, and the down entry is written before the up entry. When only one entry is allowed, the down entry is the one kept.
- R4: The store holds the last `DEPTH` entries. `fill_o` counts the entries held and stops at `DEPTH`. Older entries are overwritten.
- R5: A read request with index i returns, one cycle later with `rd_valid_o` high, the i-th oldest entry held. `rd_valid_o` is low in any cycle that follows a cycle with no request.
- R6: A trigger while armed keeps the entries of the trigger cycle and then at most `post_len_i` further entries. After that `frozen_o` is high, and strobes change neither the store nor `fill_o`. A `post_len_i` of 0 freezes the store right after the trigger cycle.
- R7: A re-arm strobe lowers `frozen_o` from the next cycle and resumes writing. A trigger while the store is already frozen or counting post-trigger entries has no effect.
- R8: Retrain and reconnect strobes are counted in their own counters, apart from the up and down counters. All counters keep counting while the store is frozen.
- R9: Each counter saturates at its all-ones value instead of wrapping.
- R10: The clear strobe sets all four counters to 0 on the next cycle, and it takes priority over an increment in the same cycle.
- R11: After reset, `fill_o` is 0, `frozen_o` is 0, `rd_valid_o` is 0 and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_evt_i | input | 1 | Link-up strobe |
| up_rsn_i | input | 2 | Cause code for the link-up strobe |
| dn_evt_i | input | 1 | Link-down strobe |
| dn_rsn_i | input | 2 | Cause code for the link-down strobe |
| retrain_i | input | 1 | Retrain occurrence strobe |
| reconnect_i | input | 1 | Reconnect occurrence strobe |
| trig_i | input | 1 | Capture trigger |
| post_len_i | input | AW+1 | Number of entries kept after the trigger cycle |
| rearm_i | input | 1 | Leave the frozen or post-trigger state and resume recording |
| clr_i | input | 1 | Clear all counters |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | AW | Read index, where 0 is the oldest entry |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | TS_W+3 | Entry that was read |
| fill_o | output | AW+1 | Number of entries held |
| frozen_o | output | 1 | Store is frozen |
| ts_o | output | TS_W | Free-running timestamp |
| up_cnt_o | output | CNT_W | Link-up count |
| dn_cnt_o | output | CNT_W | Link-down count |
| retrain_cnt_o | output | CNT_W | Retrain count |
| reconnect_cnt_o | output | CNT_W | Reconnect count |

## Verification
Two things can fall in the same cycle. The first is an up and a down transition arriving together. The second is a trigger, or a post-trigger budget that is about to run out, landing in that same cycle. The bench drives both strobes together in three cases: while armed, in the cycle of a trigger, and when only one post-trigger slot is left. A scoreboard queue holds the expected entries, and the bench reads back the frozen window. Both entries must appear with the same timestamp and the down entry first. When the budget allows only one, the down entry must be the one kept.

// File: rtl/lel_pkg.sv
package lel_pkg;
  localparam int RSN_W = 2;

  typedef enum logic [1:0] {
    RSN_RESET   = 2'd0,
    RSN_RETRAIN = 2'd1,
    RSN_POLICY  = 2'd2,
    RSN_PHYDROP = 2'd3
  } rsn_e;

  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_POST   = 2'd1,
    ST_FROZEN = 2'd2
  } cap_st_e;

  localparam logic KIND_DOWN = 1'b0;
  localparam logic KIND_UP   = 1'b1;
endpackage

// File: rtl/lel_timebase.sv
module lel_timebase #(
  parameter int TS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] ts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_o <= '0;
    else         ts_o <= ts_o + 1'b1;
  end
endmodule

// File: rtl/lel_sat_cnt.sv
module lel_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_o <= '0;
    else if (clr_i)              cnt_o <= '0;
    else if (inc_i && !(&cnt_o)) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/lel_capture_ctl.sv
module lel_capture_ctl
  import lel_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          up_i,
  input  logic          dn_i,
  input  logic          trig_i,
  input  logic          rearm_i,
  input  logic [PW-1:0] post_len_i,
  output logic          wr0_o,
  output logic          wr1_o,
  output logic          frozen_o
);
  cap_st_e       st_q, st_d;
  logic [PW-1:0] rem_q, rem_d;
  logic [1:0]    n_req, allow;

  assign n_req = {1'b0, up_i} + {1'b0, dn_i};

  always_comb begin
    unique case (st_q)
      ST_ARMED: allow = n_req;
      ST_POST:  allow = (PW'(n_req) > rem_q) ? rem_q[1:0] : n_req;
      default:  allow = 2'd0;
    endcase
  end

  assign wr0_o    = (allow != 2'd0);
  assign wr1_o    = (allow == 2'd2);
  assign frozen_o = (st_q == ST_FROZEN);

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    if (rearm_i) begin
      st_d = ST_ARMED;
    end else begin
      unique case (st_q)
        ST_ARMED: if (trig_i) begin
          rem_d = post_len_i;
          st_d  = (post_len_i == '0) ? ST_FROZEN : ST_POST;
        end
        ST_POST: begin
          rem_d = rem_q - PW'(allow);
          if (rem_d == '0) st_d = ST_FROZEN;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_ARMED;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/lel_ring.sv
module lel_ring #(
  parameter  int DEPTH = 16,
  parameter  int EW    = 19,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr0_i,
  input  logic [EW-1:0] wr0_data_i,
  input  logic          wr1_i,
  input  logic [EW-1:0] wr1_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic          rd_valid_o,
  output logic [EW-1:0] rd_data_o,
  output logic [AW:0]   fill_o
);
  logic [EW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr1_addr, base, rd_addr;
  logic [1:0]    nw;
  logic [AW+1:0] fill_sum;

  assign nw       = {1'b0, wr0_i} + {1'b0, wr1_i};
  assign wr1_addr = wr_ptr_q + 1'b1;
  assign fill_sum = {1'b0, fill_o} + (AW+2)'(nw);
  // once full, the oldest entry sits at the write pointer
  assign base     = (fill_o == (AW+1)'(DEPTH)) ? wr_ptr_q : '0;
  assign rd_addr  = base + rd_idx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_ptr_q   <= '0;
      fill_o     <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      if (wr0_i) mem_q[wr_ptr_q] <= wr0_data_i;
      if (wr1_i) mem_q[wr1_addr] <= wr1_data_i;
      wr_ptr_q   <= wr_ptr_q + AW'(nw);
      fill_o     <= (fill_sum > (AW+2)'(DEPTH)) ? (AW+1)'(DEPTH) : fill_sum[AW:0];
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= mem_q[rd_addr];
    end
  end
endmodule

// File: rtl/link_evt_logger.sv
module link_evt_logger
  import lel_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int TS_W  = 16,
  parameter  int CNT_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int EW    = TS_W + 1 + RSN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_evt_i,
  input  logic [RSN_W-1:0] up_rsn_i,
  input  logic             dn_evt_i,
  input  logic [RSN_W-1:0] dn_rsn_i,
  input  logic             retrain_i,
  input  logic             reconnect_i,
  input  logic             trig_i,
  input  logic [AW:0]      post_len_i,
  input  logic             rearm_i,
  input  logic             clr_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_idx_i,
  output logic             rd_valid_o,
  output logic [EW-1:0]    rd_data_o,
  output logic [AW:0]      fill_o,
  output logic             frozen_o,
  output logic [TS_W-1:0]  ts_o,
  output logic [CNT_W-1:0] up_cnt_o,
  output logic [CNT_W-1:0] dn_cnt_o,
  output logic [CNT_W-1:0] retrain_cnt_o,
  output logic [CNT_W-1:0] reconnect_cnt_o
);
  localparam int NCNT = 4;

  logic          wr0, wr1;
  logic [EW-1:0] ent_up, ent_dn, ent0;
  logic [NCNT-1:0]  cnt_inc;
  logic [CNT_W-1:0] cnt_val [NCNT];

  lel_timebase #(.TS_W(TS_W)) u_tb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ts_o  (ts_o)
  );

  lel_capture_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .up_i      (up_evt_i),
    .dn_i      (dn_evt_i),
    .trig_i    (trig_i),
    .rearm_i   (rearm_i),
    .post_len_i(post_len_i),
    .wr0_o     (wr0),
    .wr1_o     (wr1),
    .frozen_o  (frozen_o)
  );

  assign ent_up = {ts_o, KIND_UP,   up_rsn_i};
  assign ent_dn = {ts_o, KIND_DOWN, dn_rsn_i};
  // down has priority: it takes the first slot
  assign ent0   = dn_evt_i ? ent_dn : ent_up;

  lel_ring #(.DEPTH(DEPTH), .EW(EW)) u_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr0_i     (wr0),
    .wr0_data_i(ent0),
    .wr1_i     (wr1),
    .wr1_data_i(ent_up),
    .rd_en_i   (rd_en_i),
    .rd_idx_i  (rd_idx_i),
    .rd_valid_o(rd_valid_o),
    .rd_data_o (rd_data_o),
    .fill_o    (fill_o)
  );

  assign cnt_inc = {reconnect_i, retrain_i, dn_evt_i, up_evt_i};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    lel_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (cnt_inc[g]),
      .clr_i (clr_i),
      .cnt_o (cnt_val[g])
    );
  end

  assign up_cnt_o        = cnt_val[0];
  assign dn_cnt_o        = cnt_val[1];
  assign retrain_cnt_o   = cnt_val[2];
  assign reconnect_cnt_o = cnt_val[3];
endmodule

// File: rtl/lel_checker.sv
module lel_checker #(
  parameter  int DEPTH = 16,
  parameter  int TS_W  = 16,
  parameter  int CNT_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             up_evt_i,
  input logic             dn_evt_i,
  input logic             rearm_i,
  input logic             clr_i,
  input logic             rd_en_i,
  input logic             rd_valid_o,
  input logic [AW:0]      fill_o,
  input logic             frozen_o,
  input logic [TS_W-1:0]  ts_o,
  input logic [CNT_W-1:0] up_cnt_o,
  input logic [CNT_W-1:0] dn_cnt_o,
  input logic [CNT_W-1:0] retrain_cnt_o,
  input logic [CNT_W-1:0] reconnect_cnt_o
);
  assert_ts_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ts_o == $past(ts_o) + 1'b1);

  assert_fill_grow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frozen_o && !rearm_i && (up_evt_i || dn_evt_i) && fill_o < (AW+1)'(DEPTH))
    |=> fill_o > $past(fill_o));

  assert_fill_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o <= (AW+1)'(DEPTH));

  assert_rd_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  assert_rd_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);

  assert_frozen_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_o && !rearm_i) |=> (frozen_o && $stable(fill_o)));

  assert_rearm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> !frozen_o);

  assert_sat_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&retrain_cnt_o) && !clr_i) |=> (&retrain_cnt_o));

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (up_cnt_o == '0 && dn_cnt_o == '0 &&
               retrain_cnt_o == '0 && reconnect_cnt_o == '0));
endmodule

bind link_evt_logger lel_checker #(.DEPTH(DEPTH), .TS_W(TS_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/link_evt_logger_tb.sv
module link_evt_logger_tb;
  localparam int DEPTH = 16;
  localparam int TS_W  = 16;
  localparam int CNT_W = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int EW    = TS_W + 3;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic up_evt_i = 0, dn_evt_i = 0, retrain_i = 0, reconnect_i = 0;
  logic [1:0] up_rsn_i = 0, dn_rsn_i = 0;
  logic trig_i = 0, rearm_i = 0, clr_i = 0, rd_en_i = 0;
  logic [AW:0]   post_len_i = 0;
  logic [AW-1:0] rd_idx_i = 0;
  logic          rd_valid_o, frozen_o;
  logic [EW-1:0] rd_data_o;
  logic [AW:0]   fill_o;
  logic [TS_W-1:0]  ts_o;
  logic [CNT_W-1:0] up_cnt_o, dn_cnt_o, retrain_cnt_o, reconnect_cnt_o;

  always #4 clk_i = ~clk_i;

  link_evt_logger #(.DEPTH(DEPTH), .TS_W(TS_W), .CNT_W(CNT_W)) u_dut (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string cur_req = "R5";

  logic [EW-1:0] m_log[$];
  logic [EW-1:0] sb_q[$];
  int m_st = 0;
  int m_rem = 0;
  int m_cnt[4] = '{0, 0, 0, 0};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard as read data returns
  always @(negedge clk_i) begin
    if (rst_ni && rd_valid_o) begin
      if (sb_q.size() == 0) chk(0, cur_req, rd_data_o, 0);
      else begin
        logic [EW-1:0] e;
        e = sb_q.pop_front();
        chk(rd_data_o == e, cur_req, rd_data_o, e);
      end
    end
  end

  function automatic int sat(input int v);
    return (v < CMAX) ? v + 1 : CMAX;
  endfunction

  // one cycle of stimulus; called and returns at a negedge
  task automatic step(input bit u, input logic [1:0] ur, input bit d, input logic [1:0] dr,
                      input bit rt, input bit rc, input bit tr, input bit cl, input bit ra);
    logic [EW-1:0] ents[$];
    int allow;
    up_evt_i = u; up_rsn_i = ur; dn_evt_i = d; dn_rsn_i = dr;
    retrain_i = rt; reconnect_i = rc; trig_i = tr; clr_i = cl; rearm_i = ra;
    if (d) ents.push_back({ts_o, 1'b0, dr});
    if (u) ents.push_back({ts_o, 1'b1, ur});
    allow = (m_st == 0) ? ents.size() :
            (m_st == 1) ? ((ents.size() < m_rem) ? ents.size() : m_rem) : 0;
    for (int i = 0; i < allow; i++) begin
      m_log.push_back(ents[i]);
      if (m_log.size() > DEPTH) void'(m_log.pop_front());
    end
    if (ra) m_st = 0;
    else if (m_st == 0 && tr) begin
      m_rem = int'(post_len_i);
      m_st = (m_rem == 0) ? 2 : 1;
    end else if (m_st == 1) begin
      m_rem -= allow;
      if (m_rem == 0) m_st = 2;
    end
    if (cl) m_cnt = '{0, 0, 0, 0};
    else begin
      if (u)  m_cnt[0] = sat(m_cnt[0]);
      if (d)  m_cnt[1] = sat(m_cnt[1]);
      if (rt) m_cnt[2] = sat(m_cnt[2]);
      if (rc) m_cnt[3] = sat(m_cnt[3]);
    end
    @(negedge clk_i);
    up_evt_i = 0; dn_evt_i = 0; retrain_i = 0; reconnect_i = 0;
    trig_i = 0; clr_i = 0; rearm_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // read whole window, scoreboard compares
  task automatic dump(input string req);
    cur_req = req;
    chk(fill_o == m_log.size(), req, fill_o, m_log.size());
    for (int i = 0; i < m_log.size(); i++) begin
      sb_q.push_back(m_log[i]);
      rd_en_i = 1; rd_idx_i = AW'(i);
      @(negedge clk_i);
    end
    rd_en_i = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(sb_q.size() == 0, req, sb_q.size(), 0);
  endtask

  task automatic chk_cnt(input string req);
    chk(up_cnt_o == m_cnt[0], req, up_cnt_o, m_cnt[0]);
    chk(dn_cnt_o == m_cnt[1], req, dn_cnt_o, m_cnt[1]);
    chk(retrain_cnt_o == m_cnt[2], req, retrain_cnt_o, m_cnt[2]);
    chk(reconnect_cnt_o == m_cnt[3], req, reconnect_cnt_o, m_cnt[3]);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [TS_W-1:0] t0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R11 reset state
    chk(fill_o == 0, "R11", fill_o, 0);
    chk(frozen_o == 0, "R11", frozen_o, 0);
    chk(rd_valid_o == 0, "R11", rd_valid_o, 0);
    chk_cnt("R11");
    // R1 free-running timestamp
    t0 = ts_o;
    repeat (5) @(negedge clk_i);
    chk(ts_o == t0 + 5, "R1", ts_o, t0 + 5);

    // R2 single events, cause codes
    step(1, 2'd0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 2'd3, 0, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 1, 2'd2, 0, 0, 0, 0, 0);
    step(1, 2'd1, 0, 0, 0, 0, 0, 0, 0);
    dump("R2");

    // R3 simultaneous up and down
    step(1, 2'd2, 1, 2'd1, 0, 0, 0, 0, 0);
    idle(1);
    step(1, 2'd0, 1, 2'd3, 0, 0, 0, 0, 0);
    dump("R3");

    // R4 wrap: overwrite oldest
    for (int i = 0; i < 14; i++) step(i[0], 2'(i), !i[0], 2'(i + 1), 0, 0, 0, 0, 0);
    chk(fill_o == DEPTH, "R4", fill_o, DEPTH);
    dump("R4");

    // R8 separate counters
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    step(1, 2'd1, 0, 0, 1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk_cnt("R8");

    // R6 trigger with post_len 3, both strobes in trigger cycle
    post_len_i = 3;
    step(1, 2'd3, 1, 2'd0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 2'(i), 0, 0, 0, 0, 0, 0, 0);
    chk(frozen_o == 1, "R6", frozen_o, 1);
    // R7 trigger while frozen ignored, R8 counters still run
    step(1, 2'd2, 1, 2'd2, 1, 0, 1, 0, 0);
    chk(frozen_o == 1, "R7", frozen_o, 1);
    chk_cnt("R8");
    dump("R6");

    // R7 rearm resumes
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk(frozen_o == 0, "R7", frozen_o, 0);
    step(0, 0, 1, 2'd1, 0, 0, 0, 0, 0);
    // R3 one slot left: down kept
    post_len_i = 1;
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk(frozen_o == 0, "R6", frozen_o, 0);
    step(1, 2'd1, 1, 2'd2, 0, 0, 0, 0, 0);
    chk(frozen_o == 1, "R6", frozen_o, 1);
    dump("R3");

    // R6 post_len 0
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    post_len_i = 0;
    step(1, 2'd0, 0, 0, 0, 0, 1, 0, 0);
    chk(frozen_o == 1, "R6", frozen_o, 1);
    step(0, 0, 1, 2'd3, 0, 0, 0, 0, 0);
    dump("R6");

    // R9 saturation
    for (int i = 0; i < CMAX + 5; i++) step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk(retrain_cnt_o == CMAX, "R9", retrain_cnt_o, CMAX);
    chk_cnt("R9");

    // R10 clear beats increment
    step(1, 2'd0, 1, 2'd0, 1, 1, 0, 1, 0);
    chk_cnt("R10");
    chk(retrain_cnt_o == 0, "R10", retrain_cnt_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule